// File: doc/BRIEF.md
# Strobed Bidirectional Peripheral Port

This block connects a processor to one 8-bit peripheral bus that carries data both ways. Outbound and inbound bytes are held in two separate registers, and each direction has its own pair of handshake lines. A processor write loads the outbound register and pulls the active-low "outbound full" line low. The peripheral then pulls its acknowledge low, and for as long as it is held low the port drives the outbound byte onto the shared bus. While the peripheral's active-low strobe is low, the port captures the bus into the inbound register and raises "inbound full". A processor read of the data address then frees the inbound register.

Both directions can be pending at once. Each one produces an interrupt term gated by its own mask bit, and the two terms are combined by OR onto one request line. The masks are written through a single-bit set/clear command at the control address. A mode-set command at the same address clears every mask and every handshake flag. The acknowledge and strobe pins are asynchronous, so each passes through a synchronizer before use, and the bus output enable follows the synchronized acknowledge.

The processor side uses active-low read and write strobes together with a select and a 2-bit address. Address 0 is the data port. Address 2 reads the handshake status byte. Address 3 takes control writes. A write takes effect on the rising (trailing) edge of its strobe, using the last data presented while the strobe was low.

Top module: `strobed_bidir_port`

## Requirements
- R1: After reset the status byte reads 0x80, the request line is low and the bus output enable is low.
- R2: The trailing edge of a data-port write loads the outbound register and pulls status bit 7 (the outbound-full line, active low) to 0. Once the synchronized acknowledge is low, bit 7 returns to 1.
- R3: The bus output enable is high, and the bus output carries the outbound byte, only while the synchronized acknowledge is low.
- R4: While the synchronized strobe is low, the inbound register loads the bus and status bit 5 (inbound full) becomes 1. A data-port read returns the inbound byte, and the trailing edge of that read clears bit 5.
- R5: The inbound interrupt term is raised when inbound full, its mask (status bit 4) and a high strobe are all present. It is cleared from the start of a data-port read.
- R6: The outbound interrupt term is raised when the outbound-full line is high (buffer empty), its mask (status bit 6) is set and the acknowledge is high. It is cleared from the start of a data-port write.
- R7: The request line (also status bit 3) is the OR of the two terms, so an outbound term survives a data-port read that clears the inbound term.
- R8: An inbound strobe never changes the outbound register; a byte written earlier is still driven after a later strobe.
- R9: A control write with bit 7 clear selects a bit with bits 3:1 and gives its new value in bit 0. Index 6 writes the outbound mask, index 4 writes the inbound mask, and any other index changes nothing.
- R10: A control write with bit 7 set clears both masks, inbound full, and both interrupt terms, and returns the outbound-full line to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_sel | input | 1 | Port select from the processor |
| cpu_addr | input | 2 | 0 data, 2 status, 3 control |
| cpu_wr_n | input | 1 | Write strobe, active low |
| cpu_rd_n | input | 1 | Read strobe, active low |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data (inbound byte or status) |
| pbus_in | input | 8 | Value sampled from the shared bus |
| pbus_out | output | 8 | Outbound byte for the shared bus |
| pbus_oe | output | 1 | Bus driver enable |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| stb_n | input | 1 | Peripheral strobe, active low |
| obf_n | output | 1 | Outbound full, active low |
| ibf | output | 1 | Inbound full |
| intr | output | 1 | Combined interrupt request |

## Verification
A flag stuck in the wrong state shows up within one read of the status byte. A mask or interrupt term that failed to clear leaves the request line high in the cycle after a read or write starts. A latch corrupted by the wrong direction appears on the bus output as soon as the next acknowledge has passed the synchronizer, two clocks after it falls. A bus enable that ignores the acknowledge is seen at once as a driven bus with the acknowledge high.

// File: rtl/sbp_pkg.sv
package sbp_pkg;
   localparam logic [1:0] ADDR_DATA = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd2;
   localparam logic [1:0] ADDR_CTRL = 2'd3;

   // status byte bit positions (decoded by software)
   localparam int ST_OBF   = 7;
   localparam int ST_OMASK = 6;
   localparam int ST_IBF   = 5;
   localparam int ST_IMASK = 4;
   localparam int ST_INTR  = 3;

   // control word fields
   localparam int          CW_MODE    = 7;
   localparam logic [2:0]  IDX_OMASK  = 3'd6;
   localparam logic [2:0]  IDX_IMASK  = 3'd4;

   typedef struct packed {
      logic mode_set;
      logic omask_set;
      logic omask_clr;
      logic imask_set;
      logic imask_clr;
   } ctrl_cmd_t;
endpackage

// File: rtl/sbp_sync.sv
module sbp_sync #(
   parameter int   STAGES    = 2,
   parameter logic RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= RESET_VAL;
      else        chain[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain[i] <= RESET_VAL;
         else        chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/sbp_cpu_if.sv
module sbp_cpu_if
   import sbp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sel,
   input  logic [1:0]        cpu_addr,
   input  logic              cpu_wr_n,
   input  logic              cpu_rd_n,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] wdat,
   output logic              wr_data_active,
   output logic              wr_data_done,
   output logic              rd_data_active,
   output logic              rd_data_done,
   output ctrl_cmd_t         cmd
);
   logic              wr_act, rd_act;
   logic              wr_act_q, rd_act_q;
   logic [1:0]        wr_addr_q, rd_addr_q;
   logic [DATA_W-1:0] wdat_q;
   logic              wr_done, rd_done, ctrl_done;
   logic [2:0]        bit_idx;

   assign wr_act = cpu_sel & ~cpu_wr_n;
   assign rd_act = cpu_sel & ~cpu_rd_n;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_act_q  <= 1'b0;
         rd_act_q  <= 1'b0;
         wr_addr_q <= '0;
         rd_addr_q <= '0;
         wdat_q    <= '0;
      end else begin
         wr_act_q <= wr_act;
         rd_act_q <= rd_act;
         if (wr_act) begin
            wr_addr_q <= cpu_addr;
            wdat_q    <= cpu_wdata;
         end
         if (rd_act) rd_addr_q <= cpu_addr;
      end
   end

   // commit on the trailing edge of the strobe
   assign wr_done = wr_act_q & ~wr_act;
   assign rd_done = rd_act_q & ~rd_act;

   assign wdat           = wdat_q;
   assign wr_data_active = wr_act & (cpu_addr == ADDR_DATA);
   assign wr_data_done   = wr_done & (wr_addr_q == ADDR_DATA);
   assign rd_data_active = rd_act & (cpu_addr == ADDR_DATA);
   assign rd_data_done   = rd_done & (rd_addr_q == ADDR_DATA);

   assign ctrl_done = wr_done & (wr_addr_q == ADDR_CTRL);
   assign bit_idx   = wdat_q[3:1];

   always_comb begin
      cmd = '0;
      if (ctrl_done) begin
         if (wdat_q[CW_MODE]) begin
            cmd.mode_set = 1'b1;
         end else if (bit_idx == IDX_OMASK) begin
            cmd.omask_set = wdat_q[0];
            cmd.omask_clr = ~wdat_q[0];
         end else if (bit_idx == IDX_IMASK) begin
            cmd.imask_set = wdat_q[0];
            cmd.imask_clr = ~wdat_q[0];
         end
      end
   end
endmodule

// File: rtl/sbp_out_side.sv
module sbp_out_side
   import sbp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] wdat,
   input  logic              wr_data_active,
   input  logic              wr_data_done,
   input  logic              ack_s,
   input  ctrl_cmd_t         cmd,
   output logic              obf_n,
   output logic              out_mask,
   output logic              out_irq,
   output logic [DATA_W-1:0] pbus_out,
   output logic              pbus_oe
);
   logic [DATA_W-1:0] out_latch;
   logic              irq_q;
   logic              irq_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_latch <= '0;
      else if (wr_data_done) out_latch <= wdat;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            obf_n <= 1'b1;
      else if (cmd.mode_set) obf_n <= 1'b1;
      else if (wr_data_done) obf_n <= 1'b0;
      else if (!ack_s)       obf_n <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               out_mask <= 1'b0;
      else if (cmd.mode_set || cmd.omask_clr)   out_mask <= 1'b0;
      else if (cmd.omask_set)                   out_mask <= 1'b1;
   end

   assign irq_set = obf_n & out_mask & ack_s & ~wr_data_active & ~wr_data_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               irq_q <= 1'b0;
      else if (cmd.mode_set || wr_data_active) irq_q <= 1'b0;
      else if (irq_set)                         irq_q <= 1'b1;
   end

   assign out_irq  = irq_q & out_mask;
   assign pbus_out = out_latch;
   assign pbus_oe  = ~ack_s;
endmodule

// File: rtl/sbp_in_side.sv
module sbp_in_side
   import sbp_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pbus_in,
   input  logic              stb_s,
   input  logic              rd_data_active,
   input  logic              rd_data_done,
   input  ctrl_cmd_t         cmd,
   output logic              ibf,
   output logic              in_mask,
   output logic              in_irq,
   output logic [DATA_W-1:0] in_latch
);
   logic irq_q;
   logic irq_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      in_latch <= '0;
      else if (!stb_s) in_latch <= pbus_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            ibf <= 1'b0;
      else if (cmd.mode_set) ibf <= 1'b0;
      else if (!stb_s)       ibf <= 1'b1;
      else if (rd_data_done) ibf <= 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              in_mask <= 1'b0;
      else if (cmd.mode_set || cmd.imask_clr)  in_mask <= 1'b0;
      else if (cmd.imask_set)                  in_mask <= 1'b1;
   end

   assign irq_set = ibf & in_mask & stb_s & ~rd_data_active & ~rd_data_done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               irq_q <= 1'b0;
      else if (cmd.mode_set || rd_data_active) irq_q <= 1'b0;
      else if (irq_set)                         irq_q <= 1'b1;
   end

   assign in_irq = irq_q & in_mask;
endmodule

// File: rtl/strobed_bidir_port.sv
module strobed_bidir_port
   import sbp_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_sel,
   input  logic [1:0]        cpu_addr,
   input  logic              cpu_wr_n,
   input  logic              cpu_rd_n,
   input  logic [DATA_W-1:0] cpu_wdata,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic [DATA_W-1:0] pbus_in,
   output logic [DATA_W-1:0] pbus_out,
   output logic              pbus_oe,
   input  logic              ack_n,
   input  logic              stb_n,
   output logic              obf_n,
   output logic              ibf,
   output logic              intr
);
   if (DATA_W < 8) begin : g_bad_width
      $error("strobed_bidir_port: DATA_W must be at least 8");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("strobed_bidir_port: SYNC_STAGES must be at least 2");
   end

   logic              ack_s, stb_s;
   logic [DATA_W-1:0] wdat;
   logic              wr_data_active, wr_data_done;
   logic              rd_data_active, rd_data_done;
   ctrl_cmd_t         cmd;
   logic              out_mask, in_mask, out_irq, in_irq;
   logic [DATA_W-1:0] in_latch;
   logic [DATA_W-1:0] status;

   sbp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) ack_sync_i (
      .clk(clk), .rst_n(rst_n), .d(ack_n), .q(ack_s));
   sbp_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) stb_sync_i (
      .clk(clk), .rst_n(rst_n), .d(stb_n), .q(stb_s));

   sbp_cpu_if #(.DATA_W(DATA_W)) cpu_if_i (
      .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_addr(cpu_addr),
      .cpu_wr_n(cpu_wr_n), .cpu_rd_n(cpu_rd_n), .cpu_wdata(cpu_wdata),
      .wdat(wdat), .wr_data_active(wr_data_active), .wr_data_done(wr_data_done),
      .rd_data_active(rd_data_active), .rd_data_done(rd_data_done), .cmd(cmd));

   sbp_out_side #(.DATA_W(DATA_W)) out_i (
      .clk(clk), .rst_n(rst_n), .wdat(wdat), .wr_data_active(wr_data_active),
      .wr_data_done(wr_data_done), .ack_s(ack_s), .cmd(cmd), .obf_n(obf_n),
      .out_mask(out_mask), .out_irq(out_irq), .pbus_out(pbus_out), .pbus_oe(pbus_oe));

   sbp_in_side #(.DATA_W(DATA_W)) in_i (
      .clk(clk), .rst_n(rst_n), .pbus_in(pbus_in), .stb_s(stb_s),
      .rd_data_active(rd_data_active), .rd_data_done(rd_data_done), .cmd(cmd),
      .ibf(ibf), .in_mask(in_mask), .in_irq(in_irq), .in_latch(in_latch));

   assign intr = in_irq | out_irq;

   always_comb begin
      status           = '0;
      status[ST_OBF]   = obf_n;
      status[ST_OMASK] = out_mask;
      status[ST_IBF]   = ibf;
      status[ST_IMASK] = in_mask;
      status[ST_INTR]  = intr;
   end

   always_comb begin
      case (cpu_addr)
         ADDR_DATA: cpu_rdata = in_latch;
         ADDR_STAT: cpu_rdata = status;
         default:   cpu_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sbp_checker.sv
module sbp_checker #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stb_s,
   input logic              ibf,
   input logic              obf_n,
   input logic              in_mask,
   input logic              out_mask,
   input logic              intr,
   input logic              mode_set,
   input logic              wr_data_done,
   input logic [DATA_W-1:0] pbus_out
);
   AST_OBF_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(obf_n) |-> $past(wr_data_done)); // R2

   AST_IBF_ONLY_BY_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ibf) |-> $past(!stb_s)); // R4

   AST_INTR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      intr |-> ((ibf && in_mask) || (obf_n && out_mask))); // R7

   AST_OUT_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(wr_data_done) |-> $stable(pbus_out)); // R8

   AST_MODE_SET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      $past(mode_set) |-> (!ibf && obf_n && !in_mask && !out_mask && !intr)); // R10
endmodule

bind strobed_bidir_port sbp_checker #(.DATA_W(DATA_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .stb_s(stb_s), .ibf(ibf), .obf_n(obf_n),
   .in_mask(in_mask), .out_mask(out_mask), .intr(intr), .mode_set(cmd.mode_set),
   .wr_data_done(wr_data_done), .pbus_out(pbus_out));

// File: tb/strobed_bidir_port_tb.sv
module strobed_bidir_port_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cpu_sel = 1'b0;
   logic [1:0] cpu_addr = 2'd0;
   logic       cpu_wr_n = 1'b1;
   logic       cpu_rd_n = 1'b1;
   logic [7:0] cpu_wdata = 8'h00;
   logic [7:0] cpu_rdata;
   logic [7:0] pbus_in = 8'h00;
   logic [7:0] pbus_out;
   logic       pbus_oe;
   logic       ack_n = 1'b1;
   logic       stb_n = 1'b1;
   logic       obf_n, ibf, intr;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      string      req;
      int         what;   // 0 rdata, 1 intr, 2 oe, 3 pbus_out
      logic [7:0] val;
   } exp_t;
   exp_t exp_q[$];

   always #10 clk = ~clk;

   strobed_bidir_port dut_i (
      .clk(clk), .rst_n(rst_n), .cpu_sel(cpu_sel), .cpu_addr(cpu_addr),
      .cpu_wr_n(cpu_wr_n), .cpu_rd_n(cpu_rd_n), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .pbus_in(pbus_in), .pbus_out(pbus_out),
      .pbus_oe(pbus_oe), .ack_n(ack_n), .stb_n(stb_n), .obf_n(obf_n),
      .ibf(ibf), .intr(intr));

   // monitor: pops expectations and compares them with the outputs
   always @(negedge clk) begin
      while (exp_q.size() > 0) begin
         exp_t e;
         logic [7:0] act;
         e = exp_q.pop_front();
         case (e.what)
            0:       act = cpu_rdata;
            1:       act = {7'd0, intr};
            2:       act = {7'd0, pbus_oe};
            default: act = pbus_out;
         endcase
         checks++;
         if (act !== e.val) begin
            errors++;
            $display("FAIL %s: what=%0d actual=%02h expected=%02h", e.req, e.what, act, e.val);
         end
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic expect_val(string req, int what, logic [7:0] v);
      exp_q.push_back('{req, what, v});
      @(negedge clk);
      #1;
   endtask

   task automatic cpu_write(logic [1:0] a, logic [7:0] d);
      step(1);
      cpu_sel = 1'b1; cpu_addr = a; cpu_wdata = d; cpu_wr_n = 1'b0;
      step(2);
      cpu_wr_n = 1'b1;
      step(1);
      cpu_sel = 1'b0;
      step(1);
   endtask

   task automatic rd_begin(logic [1:0] a);
      step(1);
      cpu_sel = 1'b1; cpu_addr = a; cpu_rd_n = 1'b0;
      step(1);
   endtask

   task automatic rd_end();
      step(1);
      cpu_rd_n = 1'b1;
      step(1);
      cpu_sel = 1'b0;
      step(1);
   endtask

   task automatic chk_status(logic [7:0] v, string req);
      rd_begin(2'd2);
      expect_val(req, 0, v);
      rd_end();
   endtask

   task automatic strobe(logic [7:0] v);
      step(1);
      pbus_in = v; stb_n = 1'b0;
      step(4);
      stb_n = 1'b1;
      step(5);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(2);
      // R1 reset state
      chk_status(8'h80, "R1");
      expect_val("R1", 1, 8'h00);
      expect_val("R1", 2, 8'h00);

      // R2 / R3 outbound path
      cpu_write(2'd0, 8'h5A);
      chk_status(8'h00, "R2");
      expect_val("R3", 2, 8'h00);
      ack_n = 1'b0;
      step(4);
      expect_val("R3", 2, 8'h01);
      expect_val("R3", 3, 8'h5A);
      chk_status(8'h80, "R2");
      ack_n = 1'b1;
      step(5);
      expect_val("R3", 2, 8'h00);

      // R4 inbound path
      strobe(8'hC3);
      chk_status(8'hA0, "R4");
      rd_begin(2'd0);
      expect_val("R4", 0, 8'hC3);
      rd_end();
      chk_status(8'h80, "R4");

      // R9 / R5 inbound mask and interrupt
      cpu_write(2'd3, 8'h09);
      chk_status(8'h90, "R9");
      expect_val("R5", 1, 8'h00);
      strobe(8'h11);
      expect_val("R5", 1, 8'h01);
      chk_status(8'hB8, "R5");
      rd_begin(2'd0);
      expect_val("R5", 1, 8'h00);
      expect_val("R4", 0, 8'h11);
      rd_end();
      chk_status(8'h90, "R5");

      // R6 outbound mask and interrupt
      cpu_write(2'd3, 8'h0D);
      expect_val("R6", 1, 8'h01);
      chk_status(8'hD8, "R6");
      cpu_write(2'd0, 8'h77);
      expect_val("R6", 1, 8'h00);
      chk_status(8'h50, "R6");
      ack_n = 1'b0;
      step(4);
      expect_val("R3", 3, 8'h77);
      ack_n = 1'b1;
      step(5);
      expect_val("R6", 1, 8'h01);
      chk_status(8'hD8, "R6");

      // R7 / R8 both directions pending
      cpu_write(2'd0, 8'h33);
      chk_status(8'h50, "R7");
      strobe(8'h44);
      chk_status(8'h78, "R7");
      expect_val("R8", 3, 8'h33);
      ack_n = 1'b0;
      step(4);
      expect_val("R8", 3, 8'h33);
      ack_n = 1'b1;
      step(5);
      chk_status(8'hF8, "R7");
      rd_begin(2'd0);
      expect_val("R7", 1, 8'h01);
      expect_val("R7", 0, 8'h44);
      rd_end();
      chk_status(8'hD8, "R7");

      // R9 other index ignored
      cpu_write(2'd3, 8'h05);
      chk_status(8'hD8, "R9");

      // R10 mode set with everything pending
      cpu_write(2'd0, 8'h99);
      strobe(8'h12);
      chk_status(8'h78, "R10");
      cpu_write(2'd3, 8'h80);
      chk_status(8'h80, "R10");
      expect_val("R10", 1, 8'h00);

      // R9 mask clear
      cpu_write(2'd3, 8'h0D);
      cpu_write(2'd3, 8'h0C);
      chk_status(8'h80, "R9");

      done = 1'b1;
      step(2);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule